// File: doc/BRIEF.md
# World-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. Each entry holds a virtual page number, the world (secure or non-secure) whose request caused the entry to be filled, a physical page number, a security output bit and a lock bit. A lookup presents a virtual address and the requesting world. On a hit, the physical address and the security bit come back one cycle later. On a miss, the block asks an external walker for the descriptor and stalls until the walker answers.

Every entry is tagged with its world, so translations of both worlds live in the cache side by side. A world switch therefore needs no flush. The security bit acts as one more physical address bit. The block enforces the security rule on it: a non-secure request always gets the bit set, and a secure request gets the descriptor's value. Replacement is round-robin and skips locked entries. A single-cycle invalidate drops every entry that belongs to one world.

Top module: `wtag_tlb`

## Requirements
- R1: After reset no entry is valid, `rs_valid` and `wk_req` are 0 and `lk_ready` is 1. The first lookup after reset therefore misses.
- R2: A lookup accepted while `lk_ready` is 1 that matches a valid entry sets `rs_valid` on the next cycle. `rs_pa` is then {entry physical page, address offset bits [PAGE_W-1:0]}, and no walker request is raised.
- R3: A lookup that misses raises `wk_req` on the next cycle, with `wk_vpn` equal to address bits [VA_W-1:PAGE_W] and `wk_world` equal to the request world. `wk_req` and its fields hold and `lk_ready` stays 0 until `wk_rsp_valid`. Lookups offered during that wait are ignored.
- R4: In the cycle after `wk_rsp_valid` while `wk_req` is 1, `rs_valid` is 1 and `rs_pa` is {`wk_rsp_ppn`, pending offset}. `wk_req` is then 0 and the descriptor is installed, so a repeat lookup hits.
- R5: A hit needs the same virtual page and the same world (`lk_world`: 1 = non-secure, 0 = secure). The same page asked for by the other world misses.
- R6: When the request world is 1, `rs_ns` is 1 whatever the descriptor's security field holds.
- R7: When the request world is 0, `rs_ns` equals the `wk_rsp_ns` value of the descriptor that filled the entry.
- R8: Secure and non-secure entries for the same virtual page coexist, and both keep hitting without any flush. The same physical page under a different `rs_ns` is a separate mapping.
- R9: The victim is the first entry, counting from a rotating pointer, that is not both valid and locked. The pointer then moves to the entry after the victim. With 4 entries and none locked, fills go to entries 0,1,2,3 and the fifth fill evicts the first.
- R10: An entry filled with `wk_rsp_lock`=1 is never chosen as a victim. Any unlocked entry may be replaced by a refill from either world.
- R11: One cycle of `inv_valid` drops every entry whose world equals `inv_world`, locked ones included. Entries of the other world are kept.
- R12: When every entry is valid and locked, a miss still returns its result, but nothing is installed and the next identical lookup misses again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address of the lookup |
| lk_world | input | 1 | Request world, 1 = non-secure |
| lk_ready | output | 1 | Block can accept a lookup |
| rs_valid | output | 1 | Result pulse |
| rs_pa | output | PA_W | Translated physical address |
| rs_ns | output | 1 | Security bit of the result |
| wk_req | output | 1 | Walker request, held until the response |
| wk_vpn | output | VA_W-PAGE_W | Virtual page to walk |
| wk_world | output | 1 | World of the walk |
| wk_rsp_valid | input | 1 | Walker response strobe |
| wk_rsp_ppn | input | PA_W-PAGE_W | Physical page from the descriptor |
| wk_rsp_ns | input | 1 | Security field of the descriptor |
| wk_rsp_lock | input | 1 | Lock the installed entry |
| inv_valid | input | 1 | Invalidate-by-world strobe |
| inv_world | input | 1 | World to invalidate |

## Verification
The stimulus table sends the same virtual page from both worlds, and the same physical page with different descriptor security fields. This separates a world-blind tag compare from a correct one, and a forced security bit from a passed-through one. A sequence of fills that overflows the four entries, with one locked entry in the way, pins down the victim order and the lock skip. Later hits and misses reveal which entry each refill took. Directed cases invalidate one world while the other world holds a locked entry, fill every entry locked to check that a full cache still answers, and hold the walker back for several cycles while extra lookups are offered, to show the request stays stable and the extra lookups are ignored.

// File: rtl/wtag_tlb_pkg.sv
package wtag_tlb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } tlb_state_e;

    // Non-secure requesters never see a secure physical space.
    function automatic logic result_ns(input logic nonsec, input logic desc_ns);
        return nonsec | desc_ns;
    endfunction

endpackage

// File: rtl/wtag_tlb_match.sv
module wtag_tlb_match #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic [ENTRIES-1:0]            ent_vld,
    input  logic [ENTRIES-1:0]            ent_wld,
    input  logic [ENTRIES-1:0]            ent_ns,
    input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
    input  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn,
    input  logic [VPN_W-1:0]              q_vpn,
    input  logic                          q_wld,
    output logic                          hit,
    output logic [PPN_W-1:0]              hit_ppn,
    output logic                          hit_ns
);

    logic [ENTRIES-1:0] way_hit;

    // Tag is the virtual page plus the world that filled the entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign way_hit[g] = ent_vld[g] && (ent_wld[g] == q_wld) && (ent_vpn[g] == q_vpn);
    end

    always_comb begin
        hit_ppn = '0;
        hit_ns  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_ppn = hit_ppn | ({PPN_W{way_hit[i]}} & ent_ppn[i]);
            hit_ns  = hit_ns | (way_hit[i] & ent_ns[i]);
        end
    end

    assign hit = |way_hit;

endmodule

// File: rtl/wtag_tlb_victim.sv
module wtag_tlb_victim #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES-1:0] busy,
    input  logic [IDX_W-1:0]   ptr,
    output logic               found,
    output logic [IDX_W-1:0]   idx,
    output logic [IDX_W-1:0]   nxt_ptr
);

    // Scan from the rotating pointer for the first entry that may be replaced.
    always_comb begin
        int j;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            j = int'(ptr) + i;
            if (j >= ENTRIES) j = j - ENTRIES;
            if (!found && !busy[j]) begin
                found = 1'b1;
                idx   = IDX_W'(j);
            end
        end
        if (int'(idx) == ENTRIES - 1) nxt_ptr = '0;
        else                          nxt_ptr = idx + IDX_W'(1);
    end

endmodule

// File: rtl/wtag_tlb.sv
module wtag_tlb
    import wtag_tlb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PAGE_W  = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [VA_W-1:0]        lk_va,
    input  logic                   lk_world,
    output logic                   lk_ready,
    output logic                   rs_valid,
    output logic [PA_W-1:0]        rs_pa,
    output logic                   rs_ns,
    output logic                   wk_req,
    output logic [VA_W-PAGE_W-1:0] wk_vpn,
    output logic                   wk_world,
    input  logic                   wk_rsp_valid,
    input  logic [PA_W-PAGE_W-1:0] wk_rsp_ppn,
    input  logic                   wk_rsp_ns,
    input  logic                   wk_rsp_lock,
    input  logic                   inv_valid,
    input  logic                   inv_world
);

    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PPN_W = PA_W - PAGE_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        tlb_state_e                  st;
        logic [ENTRIES-1:0]          vld;
        logic [ENTRIES-1:0]          lck;
        logic [ENTRIES-1:0]          wld;
        logic [ENTRIES-1:0]          ns;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [IDX_W-1:0]            ptr;
        logic [VPN_W-1:0]            pend_vpn;
        logic [PAGE_W-1:0]           pend_off;
        logic                        pend_wld;
        logic                        rs_vld;
        logic [PA_W-1:0]             rs_pa;
        logic                        rs_ns;
    } tlb_reg_t;

    tlb_reg_t r_q, r_d;

    logic             m_hit;
    logic [PPN_W-1:0] m_ppn;
    logic             m_ns;
    logic             v_found;
    logic [IDX_W-1:0] v_idx;
    logic [IDX_W-1:0] v_nxt;
    logic [ENTRIES-1:0] busy;

    assign busy = r_q.vld & r_q.lck;

    wtag_tlb_match #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) match_i (
        .ent_vld (r_q.vld),
        .ent_wld (r_q.wld),
        .ent_ns  (r_q.ns),
        .ent_vpn (r_q.vpn),
        .ent_ppn (r_q.ppn),
        .q_vpn   (lk_va[VA_W-1:PAGE_W]),
        .q_wld   (lk_world),
        .hit     (m_hit),
        .hit_ppn (m_ppn),
        .hit_ns  (m_ns)
    );

    wtag_tlb_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) victim_i (
        .busy    (busy),
        .ptr     (r_q.ptr),
        .found   (v_found),
        .idx     (v_idx),
        .nxt_ptr (v_nxt)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rs_vld = 1'b0;

        // Drop one world's entries, locked or not.
        if (inv_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (r_q.wld[i] == inv_world) begin
                    r_d.vld[i] = 1'b0;
                    r_d.lck[i] = 1'b0;
                end
            end
        end

        case (r_q.st)
            ST_IDLE: begin
                if (lk_valid) begin
                    if (m_hit) begin
                        r_d.rs_vld = 1'b1;
                        r_d.rs_pa  = {m_ppn, lk_va[PAGE_W-1:0]};
                        r_d.rs_ns  = m_ns;
                    end else begin
                        r_d.st       = ST_FILL;
                        r_d.pend_vpn = lk_va[VA_W-1:PAGE_W];
                        r_d.pend_off = lk_va[PAGE_W-1:0];
                        r_d.pend_wld = lk_world;
                    end
                end
            end
            ST_FILL: begin
                if (wk_rsp_valid) begin
                    r_d.st     = ST_IDLE;
                    r_d.rs_vld = 1'b1;
                    r_d.rs_pa  = {wk_rsp_ppn, r_q.pend_off};
                    r_d.rs_ns  = result_ns(r_q.pend_wld, wk_rsp_ns);
                    if (v_found) begin
                        r_d.vld[v_idx] = 1'b1;
                        r_d.lck[v_idx] = wk_rsp_lock;
                        r_d.wld[v_idx] = r_q.pend_wld;
                        r_d.ns[v_idx]  = result_ns(r_q.pend_wld, wk_rsp_ns);
                        r_d.vpn[v_idx] = r_q.pend_vpn;
                        r_d.ppn[v_idx] = wk_rsp_ppn;
                        r_d.ptr        = v_nxt;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lk_ready = (r_q.st == ST_IDLE);
    assign wk_req   = (r_q.st == ST_FILL);
    assign wk_vpn   = r_q.pend_vpn;
    assign wk_world = r_q.pend_wld;
    assign rs_valid = r_q.rs_vld;
    assign rs_pa    = r_q.rs_pa;
    assign rs_ns    = r_q.rs_ns;

endmodule

// File: rtl/wtag_tlb_chk.sv
module wtag_tlb_chk #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic             lk_world,
    input logic             rs_valid,
    input logic [PPN_W-1:0] rs_ppn,
    input logic             rs_ns,
    input logic             wk_req,
    input logic [VPN_W-1:0] wk_vpn,
    input logic             wk_world,
    input logic             wk_rsp_valid,
    input logic [PPN_W-1:0] wk_rsp_ppn,
    input logic             wk_rsp_ns
);

    logic             req_wld_q;
    logic             fill_q;
    logic             fill_ns_q;
    logic [PPN_W-1:0] fill_ppn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_wld_q  <= 1'b0;
            fill_q     <= 1'b0;
            fill_ns_q  <= 1'b0;
            fill_ppn_q <= '0;
        end else begin
            if (lk_valid && lk_ready) req_wld_q <= lk_world;
            fill_q <= wk_req && wk_rsp_valid;
            if (wk_req && wk_rsp_valid) begin
                fill_ns_q  <= wk_rsp_ns;
                fill_ppn_q <= wk_rsp_ppn;
            end
        end
    end

    AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_ready |=> rs_valid || wk_req); // R2
    AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wk_req && !wk_rsp_valid |=> wk_req && $stable(wk_vpn) && $stable(wk_world)); // R3
    AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        wk_req |-> !lk_ready); // R3
    AST_FILL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q |-> rs_valid && !wk_req && rs_ppn == fill_ppn_q); // R4
    AST_NONSEC_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid && req_wld_q |-> rs_ns); // R6
    AST_SEC_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q && !req_wld_q |-> rs_ns == fill_ns_q); // R7

endmodule

bind wtag_tlb wtag_tlb_chk #(
    .VPN_W (VA_W - PAGE_W),
    .PPN_W (PA_W - PAGE_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_ready     (lk_ready),
    .lk_world     (lk_world),
    .rs_valid     (rs_valid),
    .rs_ppn       (rs_pa[PA_W-1:PAGE_W]),
    .rs_ns        (rs_ns),
    .wk_req       (wk_req),
    .wk_vpn       (wk_vpn),
    .wk_world     (wk_world),
    .wk_rsp_valid (wk_rsp_valid),
    .wk_rsp_ppn   (wk_rsp_ppn),
    .wk_rsp_ns    (wk_rsp_ns)
);

// File: tb/wtag_tlb_tb_top.sv
`timescale 1ns/1ps
module wtag_tlb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_world = 1'b0;
    logic        lk_ready;
    logic        rs_valid;
    logic [31:0] rs_pa;
    logic        rs_ns;
    logic        wk_req;
    logic [19:0] wk_vpn;
    logic        wk_world;
    logic        wk_rsp_valid = 1'b0;
    logic [19:0] wk_rsp_ppn = '0;
    logic        wk_rsp_ns = 1'b0;
    logic        wk_rsp_lock = 1'b0;
    logic        inv_valid = 1'b0;
    logic        inv_world = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    wtag_tlb dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_world(lk_world), .lk_ready(lk_ready),
        .rs_valid(rs_valid), .rs_pa(rs_pa), .rs_ns(rs_ns),
        .wk_req(wk_req), .wk_vpn(wk_vpn), .wk_world(wk_world),
        .wk_rsp_valid(wk_rsp_valid), .wk_rsp_ppn(wk_rsp_ppn), .wk_rsp_ns(wk_rsp_ns),
        .wk_rsp_lock(wk_rsp_lock), .inv_valid(inv_valid), .inv_world(inv_world)
    );

    typedef struct packed {
        logic        wld;
        logic [31:0] va;
        logic        miss;
        logic [19:0] ppn;
        logic        dns;
        logic        lck;
        logic [31:0] pa;
        logic        ns;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_1234, 1'b1, 20'h80001, 1'b0, 1'b0, 32'h8000_1234, 1'b0}, // R1 first miss, R7 -> e0
        '{1'b0, 32'h0000_1234, 1'b0, 20'h00000, 1'b0, 1'b0, 32'h8000_1234, 1'b0}, // R2 hit
        '{1'b1, 32'h0000_1ABC, 1'b1, 20'h80001, 1'b0, 1'b0, 32'h8000_1ABC, 1'b1}, // R5 other world misses, R6 -> e1
        '{1'b0, 32'h0000_1FFF, 1'b0, 20'h00000, 1'b0, 1'b0, 32'h8000_1FFF, 1'b0}, // R8 secure copy kept
        '{1'b1, 32'h0000_1000, 1'b0, 20'h00000, 1'b0, 1'b0, 32'h8000_1000, 1'b1}, // R8 non-secure copy, distinct ns
        '{1'b0, 32'h0002_0010, 1'b1, 20'h00042, 1'b1, 1'b1, 32'h0004_2010, 1'b1}, // R7 desc ns=1, locked e2
        '{1'b1, 32'h0003_0000, 1'b1, 20'h00077, 1'b0, 1'b0, 32'h0007_7000, 1'b1}, // -> e3
        '{1'b1, 32'h0004_0008, 1'b1, 20'h00055, 1'b1, 1'b0, 32'h0005_5008, 1'b1}, // R9 evicts secure e0
        '{1'b0, 32'h0000_1234, 1'b1, 20'h80001, 1'b0, 1'b0, 32'h8000_1234, 1'b0}, // R9 evicted, refill -> e1
        '{1'b1, 32'h0000_1ABC, 1'b1, 20'h80001, 1'b0, 1'b0, 32'h8000_1ABC, 1'b1}, // R10 skip locked e2 -> e3
        '{1'b0, 32'h0002_0FFF, 1'b0, 20'h00000, 1'b0, 1'b0, 32'h0004_2FFF, 1'b1}, // R10 locked survives
        '{1'b1, 32'h0003_0004, 1'b1, 20'h00099, 1'b0, 1'b0, 32'h0009_9004, 1'b1}, // R9 -> e0
        '{1'b1, 32'h0004_0000, 1'b1, 20'h00055, 1'b1, 1'b1, 32'h0005_5000, 1'b1}  // R9 -> e1 locked
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic wld, input logic [31:0] va, input logic miss,
                          input logic [19:0] ppn, input logic dns, input logic lck,
                          input logic [31:0] pa, input logic ns, input int hold);
        string nsreq;
        nsreq = wld ? "R6" : "R7";
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_world = wld;
        @(negedge clk);
        lk_valid = 1'b0;
        if (!miss) begin
            chk("R2 hit valid", {rs_valid, wk_req}, 2'b10);
        end else begin
            chk("R3 walk request", {rs_valid, wk_req, lk_ready, wk_world, wk_vpn},
                {1'b0, 1'b1, 1'b0, wld, va[31:12]});
            for (int k = 0; k < hold; k++) begin
                lk_valid = 1'b1; lk_va = 32'h0000_0000; lk_world = ~wld;
                @(negedge clk);
                chk("R3 request held", {wk_req, lk_ready, rs_valid, wk_vpn},
                    {1'b1, 1'b0, 1'b0, va[31:12]});
            end
            lk_valid = 1'b0;
            wk_rsp_valid = 1'b1; wk_rsp_ppn = ppn; wk_rsp_ns = dns; wk_rsp_lock = lck;
            @(negedge clk);
            wk_rsp_valid = 1'b0;
            chk("R4 fill result", {rs_valid, wk_req, lk_ready}, 3'b101);
        end
        chk("R4 physical address", rs_pa, pa);
        chk(nsreq, rs_ns, ns);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {rs_valid, wk_req, lk_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {rs_valid, wk_req, lk_ready}, 3'b001);

        for (int i = 0; i < NV; i++) begin
            lookup(VEC[i].wld, VEC[i].va, VEC[i].miss, VEC[i].ppn, VEC[i].dns,
                   VEC[i].lck, VEC[i].pa, VEC[i].ns, 0);
        end

        // R11 drop the non-secure world; locked secure e2 must remain
        @(negedge clk);
        inv_valid = 1'b1; inv_world = 1'b1;
        @(negedge clk);
        inv_valid = 1'b0;
        chk("R11 no side output", {rs_valid, wk_req}, 2'b00);
        lookup(1'b0, 32'h0002_0ABC, 1'b0, 20'h0, 1'b0, 1'b0, 32'h0004_2ABC, 1'b1, 0); // R11 secure kept
        // R11 locked non-secure entry was dropped -> miss, refill lands in e3
        lookup(1'b1, 32'h0004_0000, 1'b1, 20'h00055, 1'b0, 1'b1, 32'h0005_5000, 1'b1, 0);

        // R12 lock every remaining entry
        lookup(1'b1, 32'h0005_0000, 1'b1, 20'h00066, 1'b0, 1'b1, 32'h0006_6000, 1'b1, 0);
        lookup(1'b1, 32'h0006_0000, 1'b1, 20'h00067, 1'b0, 1'b1, 32'h0006_7000, 1'b1, 0);
        lookup(1'b0, 32'h0007_0123, 1'b1, 20'h00123, 1'b0, 1'b0, 32'h0012_3123, 1'b0, 0);
        // R12 nothing installed: misses again; R3 walker held 3 cycles, extra lookups ignored
        lookup(1'b0, 32'h0007_0123, 1'b1, 20'h00124, 1'b0, 1'b0, 32'h0012_4123, 1'b0, 3);
        // R10 locked entries of both worlds still present
        lookup(1'b1, 32'h0005_0010, 1'b0, 20'h0, 1'b0, 1'b0, 32'h0006_6010, 1'b1, 0);
        lookup(1'b0, 32'h0002_0000, 1'b0, 20'h0, 1'b0, 1'b0, 32'h0004_2000, 1'b1, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule